// File: doc/BRIEF.md
# Conversion Result Window Watchdog

This block watches the stream of finished conversion results from an analog-to-digital converter. Each result arrives with a one-cycle valid strobe, its raw 12-bit value, the number of the channel it came from, and a tag that says whether it belongs to the regular or the injected group. The block tests each result it has been told to monitor against a programmable window, set by a low bound and a high bound. A result outside that window sets a sticky alarm flag. When the interrupt enable is on, the flag also drives an interrupt request.

The monitoring scope is programmable. Either every channel is watched, or only one selected channel is. Regular-group results and injected-group results each have their own enable, and both enables may be on at once. The alarm stays set until software clears it. If a new out-of-window result arrives in the same cycle as the clear, the new result takes priority and the flag stays set.

Top module: `awd_monitor`

## Requirements
- R1: While `rst` is high and in the first cycle after it is released, `flag_o` and `irq_o` are 0.
- R2: A monitored result whose value is strictly greater than `cfg_high` sets `flag_o` on the clock edge that samples the result, so `flag_o` is 1 in the following cycle.
- R3: A monitored result whose value is strictly less than `cfg_low` sets `flag_o` in the same way.
- R4: A monitored result equal to `cfg_low`, equal to `cfg_high`, or between the two leaves `flag_o` unchanged.
- R5: When `cfg_single` is 1, only results whose `res_chan` equals `cfg_chan` are monitored. Results from all other channels never set the flag.
- R6: When `cfg_single` is 0, results from every channel number from 0 to 17 are monitored.
- R7: A result with `res_inj`=0 (regular) is monitored only when `cfg_reg_en` is 1. A result with `res_inj`=1 (injected) is monitored only when `cfg_inj_en` is 1. Both enables may be 1 at the same time.
- R8: `flag_o` stays 1 until a cycle in which `flag_clr` is 1, and it reads 0 in the cycle after that. If an out-of-window monitored result arrives in the same cycle as `flag_clr`, `flag_o` stays 1.
- R9: `irq_o` is 1 exactly when `flag_o` is 1 and `cfg_irq_en` is 1.
- R10: When `cfg_low` is greater than `cfg_high`, every monitored result sets `flag_o`.
- R11: A result with `res_chan` of 18 or more, or any cycle with `res_valid`=0, leaves `flag_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| res_valid | input | 1 | One-cycle strobe that marks a finished conversion |
| res_data | input | 12 | Raw conversion result, before any alignment |
| res_chan | input | 5 | Channel number of the result (0 to 17 are valid) |
| res_inj | input | 1 | Group of the result: 0 = regular, 1 = injected |
| cfg_low | input | 12 | Low bound of the window |
| cfg_high | input | 12 | High bound of the window |
| cfg_single | input | 1 | 1 = watch only `cfg_chan`, 0 = watch all channels |
| cfg_chan | input | 5 | Channel watched when `cfg_single` is 1 |
| cfg_reg_en | input | 1 | Enable monitoring of regular-group results |
| cfg_inj_en | input | 1 | Enable monitoring of injected-group results |
| cfg_irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Software clear of the alarm flag |
| flag_o | output | 1 | Sticky out-of-window alarm |
| irq_o | output | 1 | Interrupt request |

## Verification
The only state in the block is the alarm flag, so any fault in the scope filter, the comparator or the flag register appears on `flag_o` one cycle after the result that triggered it. The same fault appears on `irq_o` whenever interrupts are enabled. A behavioural model in the bench predicts the flag on every clock, and the stimulus walks through the cases where a wrong decision would show:
- values exactly on each bound;
- results from channels the current scope excludes;
- results from the disabled group;
- out-of-range channel numbers;
- a clear that arrives in the same cycle as an out-of-window result;
- an inverted window, with the low bound above the high bound.

// File: rtl/awd_pkg.sv
package awd_pkg;
    parameter int DATA_W = 12;
    parameter int CH_W   = 5;
    parameter int NUM_CH = 18;

    typedef enum logic {
        GRP_REGULAR  = 1'b0,
        GRP_INJECTED = 1'b1
    } grp_e;

    typedef struct packed {
        logic              valid;
        grp_e              grp;
        logic [CH_W-1:0]   chan;
        logic [DATA_W-1:0] data;
    } sample_t;

    typedef struct packed {
        logic            single;
        logic [CH_W-1:0] chan;
        logic            reg_en;
        logic            inj_en;
    } scope_cfg_t;

    typedef struct packed {
        logic [DATA_W-1:0] lo;
        logic [DATA_W-1:0] hi;
    } window_t;

    function automatic logic outside_window(input logic [DATA_W-1:0] v,
                                            input window_t w);
        return (v > w.hi) || (v < w.lo);
    endfunction
endpackage

// File: rtl/awd_scope_filter.sv
module awd_scope_filter
    import awd_pkg::*;
(
    input  logic            valid_i,
    input  grp_e            grp_i,
    input  logic [CH_W-1:0] chan_i,
    input  scope_cfg_t      cfg_i,
    output logic            watch_o
);
    localparam logic [CH_W-1:0] CH_LIMIT = CH_W'(NUM_CH);

    logic chan_legal;
    logic grp_on;
    logic chan_hit;

    always_comb begin
        chan_legal = (chan_i < CH_LIMIT);
        grp_on     = (grp_i == GRP_INJECTED) ? cfg_i.inj_en : cfg_i.reg_en;
        chan_hit   = !cfg_i.single || (chan_i == cfg_i.chan);
        watch_o    = valid_i && chan_legal && grp_on && chan_hit;
    end
endmodule

// File: rtl/awd_window_cmp.sv
module awd_window_cmp
    import awd_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    input  window_t           win_i,
    output logic              out_o
);
    always_comb out_o = outside_window(data_i, win_i);
endmodule

// File: rtl/awd_flag_reg.sv
module awd_flag_reg (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst)        flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_o);
    assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !clr_i) |=> flag_o);
    assert_cleared_R8: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/awd_monitor.sv
module awd_monitor
    import awd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    input  logic [CH_W-1:0]   res_chan,
    input  logic              res_inj,
    input  logic [DATA_W-1:0] cfg_low,
    input  logic [DATA_W-1:0] cfg_high,
    input  logic              cfg_single,
    input  logic [CH_W-1:0]   cfg_chan,
    input  logic              cfg_reg_en,
    input  logic              cfg_inj_en,
    input  logic              cfg_irq_en,
    input  logic              flag_clr,
    output logic              flag_o,
    output logic              irq_o
);
    sample_t    smp;
    scope_cfg_t scope;
    window_t    win;
    logic       watch;
    logic       outside;
    logic       alarm;

    always_comb begin
        smp.valid    = res_valid;
        smp.grp      = res_inj ? GRP_INJECTED : GRP_REGULAR;
        smp.chan     = res_chan;
        smp.data     = res_data;
        scope.single = cfg_single;
        scope.chan   = cfg_chan;
        scope.reg_en = cfg_reg_en;
        scope.inj_en = cfg_inj_en;
        win.lo       = cfg_low;
        win.hi       = cfg_high;
    end

    awd_scope_filter u_scope (
        .valid_i (smp.valid),
        .grp_i   (smp.grp),
        .chan_i  (smp.chan),
        .cfg_i   (scope),
        .watch_o (watch)
    );

    awd_window_cmp u_cmp (
        .data_i (smp.data),
        .win_i  (win),
        .out_o  (outside)
    );

    assign alarm = watch && outside;

    awd_flag_reg u_flag (
        .clk    (clk),
        .rst    (rst),
        .set_i  (alarm),
        .clr_i  (flag_clr),
        .flag_o (flag_o)
    );

    assign irq_o = flag_o && cfg_irq_en;

    assert_rise_window_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_o) |-> $past(res_valid && ((res_data > cfg_high) || (res_data < cfg_low))));
    assert_rise_group_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_o) |-> $past(res_inj ? cfg_inj_en : cfg_reg_en));
    assert_rise_single_R5: assert property (@(posedge clk) disable iff (rst)
        ($rose(flag_o) && $past(cfg_single)) |-> $past(res_chan == cfg_chan));
    assert_rise_chan_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_o) |-> $past(res_chan < CH_W'(NUM_CH)));
    assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !flag_o |-> !irq_o);
endmodule

// File: tb/awd_monitor_tb_top.sv
`timescale 1ns/1ps
module awd_monitor_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        res_valid = 1'b0;
    logic [11:0] res_data = '0;
    logic [4:0]  res_chan = '0;
    logic        res_inj = 1'b0;
    logic [11:0] cfg_low = '0;
    logic [11:0] cfg_high = 12'hFFF;
    logic        cfg_single = 1'b0;
    logic [4:0]  cfg_chan = '0;
    logic        cfg_reg_en = 1'b0;
    logic        cfg_inj_en = 1'b0;
    logic        cfg_irq_en = 1'b0;
    logic        flag_clr = 1'b0;
    logic        flag_o;
    logic        irq_o;

    int errors = 0;
    int checks = 0;
    bit exp_flag = 1'b0;

    always #2.5 clk = ~clk;

    awd_monitor dut_i (.*);

    // Behavioural model of the alarm, updated on every edge
    always @(posedge clk) begin
        int  d, lo, hi, ch;
        bit  watched, hit;
        d  = res_data; lo = cfg_low; hi = cfg_high; ch = res_chan;
        watched = res_valid && ch < 18
                  && (res_inj ? cfg_inj_en : cfg_reg_en)
                  && (!cfg_single || ch == int'(cfg_chan));
        hit = watched && (d > hi || d < lo);
        if (rst)           exp_flag <= 1'b0;
        else if (hit)      exp_flag <= 1'b1;
        else if (flag_clr) exp_flag <= 1'b0;
    end

    task automatic tick(input string req);
        @(posedge clk);
        #1;
        checks++;
        if (flag_o !== exp_flag) begin
            errors++;
            $display("FAIL %s flag_o actual=%b expected=%b t=%0t", req, flag_o, exp_flag, $time);
        end
        checks++;
        if (irq_o !== (exp_flag && cfg_irq_en)) begin
            errors++;
            $display("FAIL %s irq_o actual=%b expected=%b t=%0t", req, irq_o,
                     exp_flag && cfg_irq_en, $time);
        end
    endtask

    task automatic send(input int d, input int ch, input bit inj, input string req);
        res_valid = 1'b1; res_data = 12'(d); res_chan = 5'(ch); res_inj = inj;
        tick(req);
        res_valid = 1'b0;
    endtask

    task automatic clear(input string req);
        flag_clr = 1'b1;
        tick(req);
        flag_clr = 1'b0;
    endtask

    initial begin
        fork
            begin
                #1;
                tick("R1");
                tick("R1");
                rst = 1'b0;
                tick("R1");
                cfg_low = 12'd100; cfg_high = 12'd3000;
                cfg_reg_en = 1'b1; cfg_irq_en = 1'b1;
                send(3000, 3, 0, "R4");
                send(100, 3, 0, "R4");
                send(2000, 3, 0, "R4");
                send(3001, 3, 0, "R2");
                tick("R8");
                clear("R8");
                send(99, 0, 0, "R3");
                tick("R8");
                tick("R8");
                flag_clr = 1'b1;
                send(4095, 2, 0, "R8");
                flag_clr = 1'b0;
                clear("R8");
                send(4000, 1, 1, "R7");
                cfg_inj_en = 1'b1; cfg_reg_en = 1'b0;
                send(4000, 1, 0, "R7");
                send(4000, 1, 1, "R7");
                clear("R7");
                cfg_reg_en = 1'b1;
                send(5, 4, 0, "R7");
                clear("R7");
                send(5, 4, 1, "R7");
                clear("R7");
                cfg_single = 1'b1; cfg_chan = 5'd17;
                send(4000, 5, 0, "R5");
                send(4000, 17, 1, "R5");
                clear("R5");
                cfg_single = 1'b0;
                send(4000, 16, 0, "R6");
                clear("R6");
                send(0, 17, 1, "R6");
                clear("R6");
                send(4000, 20, 0, "R11");
                send(4000, 18, 1, "R11");
                res_data = 12'd4000;
                tick("R11");
                cfg_irq_en = 1'b0;
                send(4000, 7, 0, "R9");
                tick("R9");
                cfg_irq_en = 1'b1;
                tick("R9");
                clear("R9");
                cfg_low = 12'd2000; cfg_high = 12'd1000;
                send(1500, 9, 0, "R10");
                clear("R10");
                send(2000, 9, 1, "R10");
                clear("R10");
                tick("R8");
            end
            begin
                repeat (5000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule